// File: doc/BRIEF.md
# PLL lock and track supervisor

This block watches a phase-locked loop from the digital side and decides two status flags. LOCK says that the oscillator frequency is on target. TRACK says that the loop filter may leave its fast acquisition setting. Each flag switches on inside a narrow error band and switches off only outside a wider one, so a small wobble near one threshold cannot make a flag chatter. The block counts oscillator rising edges over a fixed run of reference cycles. The count crosses into the reference domain through a toggle handshake. The block then compares the count with an expected value, and the absolute difference is the frequency error.

The mode input picks who drives the filter. In automatic mode the hardware TRACK flag selects acquisition or tracking. In manual mode a software-written bit selects it, and an optional pair of timers tells software when the acquisition hold time has passed and when the settling time after entering tracking has passed. Any change of LOCK can raise a sticky interrupt, which software clears by writing 1. The analog loop, the charge pump and the clock selection stay outside this block.

Top module: `pll_supervisor`

## Requirements
- R1: While `rst_n` is low, `lock`, `track`, `filt_acq`, `irq`, `acq_ready` and `settle_ready` are all 0.
- R2: A measurement is the number of `vco_clk` rising edges in a window of `WIN_REF` reference cycles. The error is the absolute difference between that count and `EXP_CNT`. The first two windows after `pll_on` rises are discarded.
- R3: `lock` rises when a measurement has error <= `tol_lock_in`. It falls only when a measurement has error > `tol_lock_out`. Other measurements leave it unchanged.
- R4: With `auto_mode`=1 and `pll_on`=1, `track` rises on error <= `tol_trk_in` and falls only on error > `tol_trk_out`, and `filt_acq` is the inverse of `track`.
- R5: With `lock_ie`=1, every change of `lock` caused by a measurement, rising or falling, sets `irq` at the same clock edge.
- R6: `irq` stays set until a cycle with `irq_clr`=1 clears it. A `lock` change in the same cycle as `irq_clr` leaves `irq` set.
- R7: With `lock_ie`=0, a `lock` change leaves `irq` unchanged.
- R8: `pll_on`=0 clears `lock` at the next edge and holds `track` and `filt_acq` at 0. The forced clear never sets `irq`.
- R9: With `auto_mode`=0 and `pll_on`=1, `filt_acq` equals `acq_sw` and `track` equals its inverse, without waiting for a clock edge.
- R10: In manual mode, `acq_ready` rises at the `T_ACQ`-th reference edge after `pll_on` is seen high. It returns to 0 once the block leaves manual mode or `pll_on` goes low.
- R11: `settle_ready` rises at the `T_SETTLE`-th reference edge of continuous manual tracking (`acq_sw`=0). It falls at the first edge with `acq_sw`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control and status are in this domain |
| vco_clk | input | 1 | Oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_on | input | 1 | Loop enabled |
| auto_mode | input | 1 | 1: hardware drives filter mode; 0: software does |
| acq_sw | input | 1 | Software acquisition bit used in manual mode |
| lock_ie | input | 1 | Lock-change interrupt enable |
| irq_clr | input | 1 | Write-1 clear of the interrupt flag |
| tol_lock_in | input | CNT_W | Error bound for entering lock |
| tol_lock_out | input | CNT_W | Error bound beyond which lock is lost |
| tol_trk_in | input | CNT_W | Error bound for entering tracking |
| tol_trk_out | input | CNT_W | Error bound beyond which tracking is left |
| lock | output | 1 | Lock indicator |
| track | output | 1 | Filter in tracking |
| filt_acq | output | 1 | Filter in acquisition |
| irq | output | 1 | Sticky lock-change interrupt |
| acq_ready | output | 1 | Manual acquisition hold time elapsed |
| settle_ready | output | 1 | Manual settling time after tracking elapsed |

## Verification
The properties assume that each exit tolerance is at least its entry tolerance, that the tolerances and `lock_ie` stay constant across a measurement, and that `vco_clk` runs fast enough that a window never saturates the edge counter. The stimulus sets the four tolerances once, with entry bands narrower than exit bands. It changes only the oscillator period between long settling intervals. It picks periods whose errors sit clear of every threshold, so a count off by one at a window boundary cannot flip a flag.

// File: rtl/pll_sup_pkg.sv
`timescale 1ns/1ps
package pll_sup_pkg;

  // absolute distance between two unsigned counts
  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/pll_sup_vco_cnt.sv
`timescale 1ns/1ps
// Oscillator-domain edge counter; snapshots on each window toggle.
module pll_sup_vco_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             vco_clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic             win_tgl,
  output logic [CNT_W-1:0] hold_q,
  output logic             cap_tgl_q
);
  logic [1:0]       rst_sync_q;
  logic             vrst_n;
  logic [1:0]       en_sync_q;
  logic [2:0]       win_sync_q;
  logic             en_s, win_edge;
  logic [CNT_W-1:0] cnt_q, cnt_d, hold_d;
  logic             cap_tgl_d;

  // local reset: asserted asynchronously, released on vco_clk
  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign vrst_n = rst_sync_q[1];

  assign en_s     = en_sync_q[1];
  assign win_edge = win_sync_q[2] ^ win_sync_q[1];

  always_comb begin
    cnt_d     = cnt_q;
    hold_d    = hold_q;
    cap_tgl_d = cap_tgl_q;
    if (!en_s) begin
      cnt_d = '0;
    end else if (win_edge) begin
      hold_d    = cnt_q;
      cnt_d     = CNT_W'(1);   // this edge opens the next window
      cap_tgl_d = ~cap_tgl_q;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge vco_clk or negedge vrst_n) begin
    if (!vrst_n) begin
      en_sync_q  <= '0;
      win_sync_q <= '0;
      cnt_q      <= '0;
      hold_q     <= '0;
      cap_tgl_q  <= 1'b0;
    end else begin
      en_sync_q  <= {en_sync_q[0], en_req};
      win_sync_q <= {win_sync_q[1:0], win_tgl};
      cnt_q      <= cnt_d;
      hold_q     <= hold_d;
      cap_tgl_q  <= cap_tgl_d;
    end
  end
endmodule

// File: rtl/pll_sup_window.sv
`timescale 1ns/1ps
// Reference-domain window timer and measurement receiver.
module pll_sup_window #(
  parameter int WIN_REF = 32,
  parameter int EXP_CNT = 128,
  parameter int CNT_W   = 10
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             pll_on,
  input  logic [CNT_W-1:0] hold,
  input  logic             cap_tgl,
  output logic             win_tgl_q,
  output logic             smp_vld_q,
  output logic [CNT_W-1:0] smp_err_q
);
  localparam int WIN_W = (WIN_REF > 1) ? $clog2(WIN_REF) : 1;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam logic [1:0] SKIP = 2'd2;

  logic [WIN_W-1:0] win_cnt_q, win_cnt_d;
  logic [2:0]       cap_sync_q;
  logic [1:0]       skip_q, skip_d;
  logic             win_tgl_d, smp_vld_d, cap_edge;
  logic [CNT_W-1:0] smp_err_d, err_now;
  logic [31:0]      gap;

  assign cap_edge = cap_sync_q[2] ^ cap_sync_q[1];
  assign gap      = pll_sup_pkg::abs_gap(32'(hold), 32'(EXP_CNT));
  assign err_now  = (gap > 32'(MAXV)) ? '1 : gap[CNT_W-1:0];

  always_comb begin
    win_cnt_d = win_cnt_q;
    win_tgl_d = win_tgl_q;
    skip_d    = skip_q;
    smp_vld_d = 1'b0;
    smp_err_d = smp_err_q;
    if (!pll_on) begin
      win_cnt_d = '0;
      skip_d    = '0;
    end else begin
      if (win_cnt_q == WIN_W'(WIN_REF - 1)) begin
        win_cnt_d = '0;
        win_tgl_d = ~win_tgl_q;
      end else begin
        win_cnt_d = win_cnt_q + WIN_W'(1);
      end
      if (cap_edge) begin
        if (skip_q != SKIP) begin
          skip_d = skip_q + 2'd1;   // partial windows after enable
        end else begin
          smp_vld_d = 1'b1;
          smp_err_d = err_now;
        end
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt_q  <= '0;
      win_tgl_q  <= 1'b0;
      cap_sync_q <= '0;
      skip_q     <= '0;
      smp_vld_q  <= 1'b0;
      smp_err_q  <= '0;
    end else begin
      win_cnt_q  <= win_cnt_d;
      win_tgl_q  <= win_tgl_d;
      cap_sync_q <= {cap_sync_q[1:0], cap_tgl};
      skip_q     <= skip_d;
      smp_vld_q  <= smp_vld_d;
      smp_err_q  <= smp_err_d;
    end
  end
endmodule

// File: rtl/pll_sup_hyst.sv
`timescale 1ns/1ps
// Two-threshold flag: enters inside tol_enter, leaves beyond tol_exit.
module pll_sup_hyst #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic [CNT_W-1:0] err,
  input  logic [CNT_W-1:0] tol_enter,
  input  logic [CNT_W-1:0] tol_exit,
  output logic             state_q,
  output logic             flip
);
  logic state_d;

  always_comb begin
    state_d = state_q;
    if (clr)                                    state_d = 1'b0;
    else if (upd &&  state_q && err > tol_exit) state_d = 1'b0;
    else if (upd && !state_q && err <= tol_enter) state_d = 1'b1;
  end

  assign flip = !clr && (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pll_sup_wait.sv
`timescale 1ns/1ps
// Elapsed-time flag: done after DUR consecutive cycles of run.
module pll_sup_wait #(
  parameter int DUR = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done_q
);
  localparam int TW = $clog2(DUR + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!run) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == TW'(DUR - 1)) done_d = 1'b1;
      else                       cnt_d  = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/pll_supervisor.sv
`timescale 1ns/1ps
module pll_supervisor #(
  parameter int WIN_REF   = 32,
  parameter int EXP_CNT   = 128,
  parameter int CNT_W     = 10,
  parameter int T_ACQ     = 40,
  parameter int T_SETTLE  = 60,
  parameter bit HAS_TIMER = 1'b1
) (
  input  logic             ref_clk,
  input  logic             vco_clk,
  input  logic             rst_n,
  input  logic             pll_on,
  input  logic             auto_mode,
  input  logic             acq_sw,
  input  logic             lock_ie,
  input  logic             irq_clr,
  input  logic [CNT_W-1:0] tol_lock_in,
  input  logic [CNT_W-1:0] tol_lock_out,
  input  logic [CNT_W-1:0] tol_trk_in,
  input  logic [CNT_W-1:0] tol_trk_out,
  output logic             lock,
  output logic             track,
  output logic             filt_acq,
  output logic             irq,
  output logic             acq_ready,
  output logic             settle_ready
);
  logic [CNT_W-1:0] hold, smp_err;
  logic             cap_tgl, win_tgl, smp_vld;
  logic             trk_hw, lock_flip, trk_flip;
  logic             irq_d, man_on;

  pll_sup_vco_cnt #(.CNT_W(CNT_W)) u_vco (
    .vco_clk(vco_clk), .rst_n(rst_n), .en_req(pll_on), .win_tgl(win_tgl),
    .hold_q(hold), .cap_tgl_q(cap_tgl)
  );

  pll_sup_window #(.WIN_REF(WIN_REF), .EXP_CNT(EXP_CNT), .CNT_W(CNT_W)) u_win (
    .ref_clk(ref_clk), .rst_n(rst_n), .pll_on(pll_on), .hold(hold),
    .cap_tgl(cap_tgl), .win_tgl_q(win_tgl), .smp_vld_q(smp_vld), .smp_err_q(smp_err)
  );

  pll_sup_hyst #(.CNT_W(CNT_W)) u_lock (
    .clk(ref_clk), .rst_n(rst_n), .clr(!pll_on), .upd(smp_vld), .err(smp_err),
    .tol_enter(tol_lock_in), .tol_exit(tol_lock_out), .state_q(lock), .flip(lock_flip)
  );

  pll_sup_hyst #(.CNT_W(CNT_W)) u_trk (
    .clk(ref_clk), .rst_n(rst_n), .clr(!pll_on), .upd(smp_vld), .err(smp_err),
    .tol_enter(tol_trk_in), .tol_exit(tol_trk_out), .state_q(trk_hw), .flip(trk_flip)
  );

  // filter-mode source: hardware flag or software bit
  assign track    = pll_on && (auto_mode ? trk_hw  : !acq_sw);
  assign filt_acq = pll_on && (auto_mode ? !trk_hw : acq_sw);

  // new lock event has priority over the clear write
  assign irq_d = (lock_flip && lock_ie) || (irq && !irq_clr);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  assign man_on = pll_on && !auto_mode;

  generate
    if (HAS_TIMER) begin : g_timer
      pll_sup_wait #(.DUR(T_ACQ)) u_acq_wait (
        .clk(ref_clk), .rst_n(rst_n), .run(man_on), .done_q(acq_ready)
      );
      pll_sup_wait #(.DUR(T_SETTLE)) u_settle_wait (
        .clk(ref_clk), .rst_n(rst_n), .run(man_on && !acq_sw), .done_q(settle_ready)
      );
    end else begin : g_no_timer
      assign acq_ready    = 1'b0;
      assign settle_ready = 1'b0;
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = trk_flip;
endmodule

// File: rtl/pll_supervisor_chk.sv
`timescale 1ns/1ps
module pll_supervisor_chk #(
  parameter int CNT_W = 10
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             pll_on,
  input logic             auto_mode,
  input logic             acq_sw,
  input logic             lock_ie,
  input logic             irq_clr,
  input logic             smp_vld,
  input logic [CNT_W-1:0] smp_err,
  input logic [CNT_W-1:0] tol_lock_in,
  input logic [CNT_W-1:0] tol_lock_out,
  input logic             lock,
  input logic             irq,
  input logic             acq_ready,
  input logic             settle_ready
);
  p_lock_keep_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_on && smp_vld && lock && smp_err <= tol_lock_out |=> lock);
  p_unlock_keep_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_on && smp_vld && !lock && smp_err > tol_lock_in |=> !lock);
  p_irq_on_change_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_on && lock_ie && smp_vld &&
    (lock ? (smp_err > tol_lock_out) : (smp_err <= tol_lock_in)) |=> irq);
  p_irq_sticky_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  p_irq_masked_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !lock_ie && !irq |=> !irq);
  p_off_unlock_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pll_on |=> !lock);
  p_off_quiet_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pll_on && !irq |=> !irq);
  p_acq_rdy_src_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(acq_ready) |-> $past(pll_on && !auto_mode));
  p_settle_drop_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    acq_sw |=> !settle_ready);
endmodule

bind pll_supervisor pll_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .pll_on(pll_on), .auto_mode(auto_mode),
  .acq_sw(acq_sw), .lock_ie(lock_ie), .irq_clr(irq_clr), .smp_vld(smp_vld),
  .smp_err(smp_err), .tol_lock_in(tol_lock_in), .tol_lock_out(tol_lock_out),
  .lock(lock), .irq(irq), .acq_ready(acq_ready), .settle_ready(settle_ready)
);

// File: tb/pll_supervisor_bench.sv
`timescale 1ns/1ps
module pll_supervisor_bench;
  localparam int CNT_W    = 10;
  localparam int T_ACQ    = 40;
  localparam int T_SETTLE = 60;
  localparam int SETTLE_CYC = 256;   // eight measurement windows
  localparam int NV = 9;

  // oscillator period in ps; expected lock and track after settling.
  // window = 32 x 20 ns = 640 ns, target 128 edges (5 ns).
  localparam int VEC_PER  [NV] = '{5000, 5120, 5350, 5120, 6000, 5120, 5000, 4000, 5000};
  localparam bit VEC_LOCK [NV] = '{1,    1,    0,    0,    0,    0,    1,    0,    1   };
  localparam bit VEC_TRK  [NV] = '{1,    1,    1,    1,    0,    1,    1,    0,    1   };

  logic ref_clk = 1'b0;
  logic vco_clk = 1'b0;
  logic rst_n, pll_on, auto_mode, acq_sw, lock_ie, irq_clr;
  logic [CNT_W-1:0] tol_lock_in, tol_lock_out, tol_trk_in, tol_trk_out;
  logic lock, track, filt_acq, irq, acq_ready, settle_ready;
  realtime vco_half = 2.5;
  int n_cmp = 0;
  int n_mis = 0;
  bit done = 1'b0;

  always #10 ref_clk = ~ref_clk;
  always #(vco_half) vco_clk = ~vco_clk;

  pll_supervisor #(.CNT_W(CNT_W), .T_ACQ(T_ACQ), .T_SETTLE(T_SETTLE)) u_pll_supervisor (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .pll_on(pll_on),
    .auto_mode(auto_mode), .acq_sw(acq_sw), .lock_ie(lock_ie), .irq_clr(irq_clr),
    .tol_lock_in(tol_lock_in), .tol_lock_out(tol_lock_out),
    .tol_trk_in(tol_trk_in), .tol_trk_out(tol_trk_out),
    .lock(lock), .track(track), .filt_acq(filt_acq), .irq(irq),
    .acq_ready(acq_ready), .settle_ready(settle_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_period(input int ps);
    vco_half = (ps / 2) * 1ps;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    bit prev_lock;
    bit seen;
    rst_n = 1'b0; pll_on = 1'b0; auto_mode = 1'b1; acq_sw = 1'b0;
    lock_ie = 1'b1; irq_clr = 1'b0;
    tol_lock_in = 10'd1; tol_lock_out = 10'd6;
    tol_trk_in  = 10'd4; tol_trk_out  = 10'd10;
    repeat (4) @(negedge ref_clk);
    // R1 reset state
    chk("R1 lock",  int'(lock), 0);   chk("R1 track", int'(track), 0);
    chk("R1 filt_acq", int'(filt_acq), 0); chk("R1 irq", int'(irq), 0);
    chk("R1 acq_ready", int'(acq_ready), 0); chk("R1 settle_ready", int'(settle_ready), 0);
    rst_n = 1'b1;
    @(negedge ref_clk);
    pll_on = 1'b1;

    // table walk: R2 measurement, R3/R4 hysteresis, R5 interrupt, R6 clear
    prev_lock = 1'b0;
    for (int i = 0; i < NV; i++) begin
      set_period(VEC_PER[i]);
      repeat (SETTLE_CYC) @(negedge ref_clk);
      chk($sformatf("R2/R3 lock row %0d", i), int'(lock), int'(VEC_LOCK[i]));
      chk($sformatf("R4 track row %0d", i), int'(track), int'(VEC_TRK[i]));
      chk($sformatf("R4 filt_acq row %0d", i), int'(filt_acq), int'(!VEC_TRK[i]));
      chk($sformatf("R5 irq row %0d", i), int'(irq), int'(VEC_LOCK[i] != prev_lock));
      prev_lock = VEC_LOCK[i];
      irq_clr = 1'b1;
      @(negedge ref_clk);
      irq_clr = 1'b0;
      chk($sformatf("R6 irq cleared row %0d", i), int'(irq), 0);
    end

    // R8: turning off drops flags without an interrupt
    pll_on = 1'b0;
    repeat (4) @(negedge ref_clk);
    chk("R8 lock off", int'(lock), 0);
    chk("R8 track off", int'(track), 0);
    chk("R8 filt_acq off", int'(filt_acq), 0);
    chk("R8 no irq", int'(irq), 0);

    // R7: lock rises with interrupt disabled
    lock_ie = 1'b0;
    pll_on = 1'b1;
    set_period(5000);
    repeat (SETTLE_CYC) @(negedge ref_clk);
    chk("R7 lock", int'(lock), 1);
    chk("R7 irq masked", int'(irq), 0);

    // R6: lock loss while clear is held, event wins
    lock_ie = 1'b1;
    irq_clr = 1'b1;
    set_period(6000);
    seen = 1'b0;
    for (int k = 0; k < 600 && !seen; k++) begin
      @(negedge ref_clk);
      if (!lock) seen = 1'b1;
    end
    chk("R6 lock fell", int'(seen), 1);
    chk("R6 event beats clear", int'(irq), 1);
    @(negedge ref_clk);
    chk("R6 clear next cycle", int'(irq), 0);
    irq_clr = 1'b0;

    // manual mode: R9 filter select, R10/R11 timers
    pll_on = 1'b0; auto_mode = 1'b0; acq_sw = 1'b1;
    set_period(5000);
    repeat (3) @(negedge ref_clk);
    chk("R10 acq_ready off", int'(acq_ready), 0);
    pll_on = 1'b1;
    #1;
    chk("R9 filt_acq acq", int'(filt_acq), 1);
    chk("R9 track acq", int'(track), 0);
    repeat (T_ACQ - 1) @(posedge ref_clk);
    @(negedge ref_clk);
    chk("R10 acq_ready early", int'(acq_ready), 0);
    @(posedge ref_clk); @(negedge ref_clk);
    chk("R10 acq_ready on time", int'(acq_ready), 1);
    acq_sw = 1'b0;
    #1;
    chk("R9 filt_acq trk", int'(filt_acq), 0);
    chk("R9 track trk", int'(track), 1);
    repeat (T_SETTLE - 1) @(posedge ref_clk);
    @(negedge ref_clk);
    chk("R11 settle early", int'(settle_ready), 0);
    @(posedge ref_clk); @(negedge ref_clk);
    chk("R11 settle on time", int'(settle_ready), 1);
    acq_sw = 1'b1;
    @(negedge ref_clk);
    chk("R11 settle drops", int'(settle_ready), 0);
    chk("R10 acq_ready held", int'(acq_ready), 1);
    auto_mode = 1'b1;
    @(negedge ref_clk); @(negedge ref_clk);
    chk("R10 acq_ready leaves manual", int'(acq_ready), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule